// File: doc/BRIEF.md
# Interrupt Distributor Register Front End

This block is the register-bus front end of an interrupt distributor. Each request carries an address inside a 4 KB window, write data, a size code (byte, halfword, word), a write flag and a secure attribute. The block works out which region the address falls in and whether that region accepts the given size. It then performs the access, or it answers with an error. Exactly one cycle after each request it returns read data and an error flag.

Only three regions hold real state. The first is a control word, seen in full by a secure requester and through a mask by a non-secure one. The second is a per-interrupt array of priority bytes. The third is the region of affinity-routing bits, which read as constant ones. Affinity routing is taken as permanently on, so the legacy target array and the software-interrupt set/clear pending windows complete without error, read as zero and drop writes. The priority bytes of interrupts 0 to 31 behave the same way. A write-only generate register reads as zero. Every priority write that lands on a real entry raises a one-cycle update strobe. The strobe carries the interrupt number and a lane mask, so that downstream logic can re-evaluate those interrupts.

Top module: `irqd_regfront`

## Requirements
- R1: Byte accesses (size code 0) are accepted only in the priority array (0x400–0x7FF), the target array (0x800–0xBFF) and the software-pending windows (0xF10–0xF2F). A byte access anywhere else, the control word at 0x000 included, answers with an error and read data 0.
- R2: Byte or word accesses to the target array and to the software-pending windows answer without error and read 0. Writes there leave no trace: a later read still returns 0 and no update strobe appears.
- R3: A byte write at 0x400+n sets the priority of interrupt n to write-data bits [7:0]. A byte read returns that priority in read-data bits [7:0]. A word access at 0x400+4k covers interrupts 4k to 4k+3, with byte lane i (bits [8i+7:8i]) belonging to interrupt 4k+i.
- R4: The priority bytes of interrupts 0 to 31, and of interrupts at or above NUM_IRQ, read as 0, ignore writes and produce no update strobe.
- R5: Every halfword access (size code 1) and every access with the reserved size code 3 answers with an error, whatever the address.
- R6: A word access (size code 2) whose address is not 4-byte aligned, or whose address lies in no region, answers with an error. No state changes.
- R7: The write-only register at 0xF00 accepts word writes without error, and a word read of it returns 0 without error.
- R8: While the disable-security bit (control bit 6) is 0, a non-secure read of the control word returns only bits 31, 4 and 1 of the full word. A secure read, or any read while bit 6 is 1, returns the full word.
- R9: Control bits 4 and 5 always read as 1 and bit 31 reads as 0. A secure write, or any write while bit 6 is 1, updates bits 0, 1, 2 and 6. A non-secure write while bit 6 is 0 updates bit 1 only.
- R10: A priority write that changes at least one real entry (an interrupt from 32 to NUM_IRQ-1) raises the update strobe in the cycle after the request. The strobe carries the interrupt number of lane 0 and a 4-bit mask of the lanes written.
- R11: After reset the response and update outputs are low, the control word reads 0x00000030 and all priorities are 0. Each accepted request produces exactly one response, one cycle later, and back-to-back requests are allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the register window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data; a byte write uses bits [7:0] |
| req_secure | input | 1 | Request comes from the secure state |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data; 0 for writes and errors |
| rsp_err | output | 1 | Request rejected |
| upd_valid | output | 1 | Priority update strobe |
| upd_irq | output | 10 | Interrupt number of lane 0 of the update |
| upd_mask | output | 4 | Lanes whose priority was written |

## Verification
The situation hardest to reach from the ports is a non-secure control write. What it may change depends on the disable-security bit, and that bit can only be set by an earlier secure write. The stimulus therefore first fills the control word from the secure side with the bit clear. It then issues non-secure writes and reads and checks them against both the masked and the full view. Only after that does it set the bit from the secure side and repeat the non-secure accesses. The other hard point is a priority word that straddles the boundary between the ignored interrupts below 32 and the real ones above it. Words at 0x41C and 0x420 are written and read back from both sides of that boundary, and the strobe queue expects nothing for the lower one.

// File: rtl/irqd_pkg.sv
// Package: shared constants and types for the distributor register front end.
// Assumes a 4 KB register window addressed in bytes.
package irqd_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int IRQ_W  = 10;            // 1024 priority bytes in the array
    localparam int FIRST_SHARED = 32;      // lowest interrupt with a real priority

    localparam logic [ADDR_W-1:0] OFS_CTL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_GEN     = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = 12'hF10;
    localparam logic [ADDR_W-1:0] OFS_PEND_HI = 12'hF2F;

    // Control word layout
    localparam logic [DATA_W-1:0] CTL_ROUTE_ONES = 32'h0000_0030;
    localparam logic [DATA_W-1:0] CTL_WMASK_FULL = 32'h0000_0047;
    localparam logic [DATA_W-1:0] CTL_WMASK_NS   = 32'h0000_0002;
    localparam logic [DATA_W-1:0] CTL_NS_VIEW    = 32'h8000_0012;
    localparam int CTL_DS_BIT = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTL,
        RG_PRIO,
        RG_ZERO,
        RG_GEN
    } region_e;

    typedef struct packed {
        region_e region;
        logic    err;
        logic    byte_mode;
    } dec_t;

endpackage

// File: rtl/irqd_decode.sv
// Module: address and size decoder.
// Maps a request to a region and flags region/size mismatches.
// Assumes no state; the result is used in the same cycle.
module irqd_decode
    import irqd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);

    region_e raw_region;
    logic    is_byte;
    logic    is_word;
    logic    aligned;
    logic    size_ok;

    assign is_byte = (size == SZ_BYTE);
    assign is_word = (size == SZ_WORD);
    assign aligned = (addr[1:0] == 2'b00);

    // Region lookup from the address alone
    always_comb begin
        raw_region = RG_NONE;
        if (addr == OFS_CTL)
            raw_region = RG_CTL;
        else if (addr[11:10] == 2'b01)
            raw_region = RG_PRIO;
        else if (addr[11:10] == 2'b10)
            raw_region = RG_ZERO;
        else if (addr >= OFS_PEND_LO && addr <= OFS_PEND_HI)
            raw_region = RG_ZERO;
        else if (addr == OFS_GEN)
            raw_region = RG_GEN;
    end

    // Size acceptance per region
    always_comb begin
        case (raw_region)
            RG_CTL, RG_GEN:  size_ok = is_word && aligned;
            RG_PRIO, RG_ZERO: size_ok = is_byte || (is_word && aligned);
            default:         size_ok = 1'b0;
        endcase
    end

    // Final decode result; a rejected access selects no region
    always_comb begin
        dec.err       = !size_ok;
        dec.region    = size_ok ? raw_region : RG_NONE;
        dec.byte_mode = is_byte;
    end

endmodule

// File: rtl/irqd_ctl_reg.sv
// Module: distributor control word.
// Holds the writable control bits. Returns the view for the requester's
// security state. Assumes the caller qualifies wr_en with a decoded word access.
module irqd_ctl_reg
    import irqd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              secure,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_view,
    output logic              sec_off
);

    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] full_view;
    logic [DATA_W-1:0] wmask;
    logic              wide;

    assign sec_off   = ctl_q[CTL_DS_BIT];
    assign wide      = secure || sec_off;
    assign wmask     = wide ? CTL_WMASK_FULL : CTL_WMASK_NS;
    assign full_view = ctl_q | CTL_ROUTE_ONES;
    assign rd_view   = wide ? full_view : (full_view & CTL_NS_VIEW);

    // Masked update of the stored control bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= (ctl_q & ~wmask) | (wdata & wmask);
    end

    // R9: a narrow non-secure write touches bit 1 only
    p_ns_write_scope_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !secure && !sec_off) |=> (((ctl_q ^ $past(ctl_q)) & ~CTL_WMASK_NS) == '0));

    // R9: the stored word never holds bits outside the writable set
    p_no_stray_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctl_q & ~CTL_WMASK_FULL) == '0));

endmodule

// File: rtl/irqd_prio_store.sv
// Module: per-interrupt priority bytes with update strobe.
// Covers one byte or one 4-byte word per access. Lanes whose interrupt is
// below FIRST_SHARED or at/above NUM_IRQ read zero and ignore writes.
// Assumes irq_base is 4-aligned for word accesses.
module irqd_prio_store
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              byte_mode,
    input  logic [IRQ_W-1:0]  irq_base,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              upd_valid,
    output logic [IRQ_W-1:0]  upd_irq,
    output logic [LANES-1:0]  upd_mask
);

    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [7:0]       prio_q [FIRST_SHARED:NUM_IRQ-1];
    logic [IRQ_W-1:0] lane_irq [LANES];
    logic [LANES-1:0] lane_ok;
    logic [7:0]       lane_wbyte [LANES];

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        // Lane decode: interrupt number, validity, write byte, read byte
        assign lane_irq[ln]   = irq_base + IRQ_W'(ln);
        assign lane_ok[ln]    = (byte_mode ? (ln == 0) : 1'b1)
                              && (int'(lane_irq[ln]) >= FIRST_SHARED)
                              && (int'(lane_irq[ln]) < NUM_IRQ);
        assign lane_wbyte[ln] = byte_mode ? wdata[7:0] : wdata[8*ln +: 8];
        assign rd_data[8*ln +: 8] = lane_ok[ln] ? prio_q[lane_irq[ln][IDX_W-1:0]] : 8'h00;
    end

    // Storage update for the written lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = FIRST_SHARED; i < NUM_IRQ; i++)
                prio_q[i] <= 8'h00;
        end else if (wr_en) begin
            for (int ln = 0; ln < LANES; ln++)
                if (lane_ok[ln])
                    prio_q[lane_irq[ln][IDX_W-1:0]] <= lane_wbyte[ln];
        end
    end

    // Update strobe registered alongside the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_irq   <= '0;
            upd_mask  <= '0;
        end else begin
            upd_valid <= wr_en && (lane_ok != '0);
            upd_irq   <= irq_base;
            upd_mask  <= wr_en ? lane_ok : '0;
        end
    end

    // R4: a strobe never names an interrupt below the shared range
    p_no_low_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_irq) >= FIRST_SHARED));

    // R10: a strobe always follows a write of the previous cycle
    p_strobe_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(wr_en));

    // R10: a byte update marks lane 0 alone
    p_byte_single_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && byte_mode) |=> ($countones(upd_mask) <= 1));

endmodule

// File: rtl/irqd_regfront.sv
// Module: top of the distributor register front end.
// Decodes each request, performs it on the control word or the priority
// store, and returns a registered response one cycle later.
// Assumes the requester accepts a response every cycle.
module irqd_regfront
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              upd_valid,
    output logic [IRQ_W-1:0]  upd_irq,
    output logic [LANES-1:0]  upd_mask
);

    dec_t              dec;
    logic              ctl_wr;
    logic              prio_wr;
    logic [DATA_W-1:0] ctl_view;
    logic [DATA_W-1:0] prio_rd;
    logic [DATA_W-1:0] rd_mux;
    logic              ctl_sec_off;

    irqd_decode u_decode (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    assign ctl_wr  = req_valid && req_write && (dec.region == RG_CTL);
    assign prio_wr = req_valid && req_write && (dec.region == RG_PRIO);

    irqd_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .secure  (req_secure),
        .wdata   (req_wdata),
        .rd_view (ctl_view),
        .sec_off (ctl_sec_off)
    );

    irqd_prio_store #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prio_wr),
        .byte_mode (dec.byte_mode),
        .irq_base  (req_addr[IRQ_W-1:0]),
        .wdata     (req_wdata),
        .rd_data   (prio_rd),
        .upd_valid (upd_valid),
        .upd_irq   (upd_irq),
        .upd_mask  (upd_mask)
    );

    // Read data selection by region
    always_comb begin
        case (dec.region)
            RG_CTL:  rd_mux = ctl_view;
            RG_PRIO: rd_mux = dec.byte_mode ? {24'h0, prio_rd[7:0]} : prio_rd;
            default: rd_mux = '0;
        endcase
    end

    // Registered response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.err;
            rsp_rdata <= (req_valid && !req_write && !dec.err) ? rd_mux : '0;
        end
    end

    // R11: every request is answered in the following cycle
    p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11: no response without a request
    p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5: halfword and reserved sizes are always rejected
    p_half_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size[0]) |=> (rsp_err && rsp_rdata == '0));

    // R8: a narrow non-secure control read carries only bits 31, 4 and 1
    p_ns_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && !ctl_sec_off
         && req_addr == OFS_CTL && req_size == SZ_WORD)
        |=> ((rsp_rdata & ~CTL_NS_VIEW) == '0));

    // R2: the zero regions never return data
    p_zero_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec.region == RG_ZERO) |=> (rsp_rdata == '0 && !rsp_err));

endmodule

// File: tb/irqd_regfront_bench.sv
// Bench: scoreboard for the distributor register front end.
// The driver queues the expected response and update items; monitors pop
// and compare them when the design produces results.
module irqd_regfront_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_secure = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        upd_valid;
    logic [9:0]  upd_irq;
    logic [3:0]  upd_mask;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [31:0] data;
        logic        err;
        string       tag;
    } rsp_item_t;

    typedef struct {
        int          at;
        logic [9:0]  irq;
        logic [3:0]  mask;
        string       tag;
    } upd_item_t;

    rsp_item_t rsp_q[$];
    upd_item_t upd_q[$];

    irqd_regfront u_irqd_regfront (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .upd_valid(upd_valid), .upd_irq(upd_irq), .upd_mask(upd_mask)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: one request per call, expected response queued
    task automatic acc(input logic w, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input logic sec,
                       input logic [31:0] exp_d, input logic exp_e, input string tag);
        rsp_item_t it;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = w;
        req_addr   = a;
        req_size   = sz;
        req_wdata  = d;
        req_secure = sec;
        it.at = cyc; it.data = exp_d; it.err = exp_e; it.tag = tag;
        rsp_q.push_back(it);
    endtask

    // Expect an update strobe for the request just driven
    task automatic exp_upd(input logic [9:0] irq, input logic [3:0] mask, input string tag);
        upd_item_t it;
        it.at = cyc; it.irq = irq; it.mask = mask; it.tag = tag;
        upd_q.push_back(it);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Response monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_q.size() > 0 && rsp_q[0].at == cyc - 1) begin
                rsp_item_t e;
                e = rsp_q.pop_front();
                vectors++;
                if (rsp_valid !== 1'b1 || rsp_err !== e.err || rsp_rdata !== e.data) begin
                    miscompares++;
                    $display("FAIL %s: valid=%b err=%b data=%08h expected valid=1 err=%b data=%08h",
                             e.tag, rsp_valid, rsp_err, rsp_rdata, e.err, e.data);
                end
            end else if (rsp_valid !== 1'b0) begin
                vectors++;
                miscompares++;
                $display("FAIL R11 unrequested response: valid=%b expected 0", rsp_valid);
            end
        end
    end

    // Update strobe monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (upd_q.size() > 0 && upd_q[0].at == cyc - 1) begin
                upd_item_t e;
                e = upd_q.pop_front();
                vectors++;
                if (upd_valid !== 1'b1 || upd_irq !== e.irq || upd_mask !== e.mask) begin
                    miscompares++;
                    $display("FAIL %s: upd valid=%b irq=%0d mask=%b expected valid=1 irq=%0d mask=%b",
                             e.tag, upd_valid, upd_irq, upd_mask, e.irq, e.mask);
                end
            end else if (upd_valid !== 1'b0) begin
                vectors++;
                miscompares++;
                $display("FAIL R10 R4 unexpected strobe: irq=%0d mask=%b expected no strobe",
                         upd_irq, upd_mask);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        vectors++;
        if (rsp_valid !== 1'b0 || upd_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R11 reset: rsp_valid=%b upd_valid=%b expected 0 0", rsp_valid, upd_valid);
        end

        // R11 / R9: control word after reset
        acc(0, 12'h000, 2'd2, 0, 1, 32'h0000_0030, 0, "R11 reset ctl read");
        acc(0, 12'h440, 2'd0, 0, 1, 32'h0, 0, "R11 reset prio read");
        // R1: byte access to control word
        acc(0, 12'h000, 2'd0, 0, 1, 32'h0, 1, "R1 byte ctl read");
        acc(1, 12'h000, 2'd0, 32'hFF, 1, 32'h0, 1, "R1 byte ctl write");
        acc(0, 12'hF00, 2'd0, 0, 1, 32'h0, 1, "R1 byte gen reg");
        acc(0, 12'hF30, 2'd0, 0, 1, 32'h0, 1, "R1 byte past pending window");
        // R5: halfword and reserved sizes
        acc(0, 12'h400, 2'd1, 0, 1, 32'h0, 1, "R5 half read prio");
        acc(1, 12'hF10, 2'd1, 32'h1, 0, 32'h0, 1, "R5 half write pending");
        acc(0, 12'h000, 2'd3, 0, 1, 32'h0, 1, "R5 reserved size");
        acc(1, 12'h440, 2'd1, 32'h77, 1, 32'h0, 1, "R5 half write prio");

        // R9 / R8: secure fill with disable-security clear
        acc(1, 12'h000, 2'd2, 32'hFFFF_FFBF, 1, 32'h0, 0, "R9 secure ctl write");
        acc(0, 12'h000, 2'd2, 0, 1, 32'h0000_0037, 0, "R9 secure ctl readback");
        acc(0, 12'h000, 2'd2, 0, 0, 32'h0000_0012, 0, "R8 ns filtered view");
        acc(1, 12'h000, 2'd2, 32'h0, 0, 32'h0, 0, "R9 ns narrow write");
        acc(0, 12'h000, 2'd2, 0, 1, 32'h0000_0035, 0, "R9 ns write touched bit 1 only");
        acc(0, 12'h000, 2'd2, 0, 0, 32'h0000_0010, 0, "R8 ns view after clear");
        acc(1, 12'h000, 2'd2, 32'h0000_0002, 0, 32'h0, 0, "R9 ns set bit 1");
        acc(0, 12'h000, 2'd2, 0, 1, 32'h0000_0037, 0, "R9 bit 1 set by ns");

        // R3 / R10: byte priority write and readback
        acc(1, 12'h428, 2'd0, 32'hFFFF_FFA5, 1, 32'h0, 0, "R3 byte prio write");
        exp_upd(10'd40, 4'b0001, "R10 byte strobe irq 40");
        acc(0, 12'h428, 2'd0, 0, 1, 32'h0000_00A5, 0, "R3 byte prio readback");
        acc(0, 12'h428, 2'd2, 0, 0, 32'h0000_00A5, 0, "R3 word view of irq 40");
        // R4: word straddling the low boundary from below
        acc(1, 12'h41C, 2'd2, 32'hDEAD_BEEF, 1, 32'h0, 0, "R4 word write irq 28-31");
        acc(0, 12'h41C, 2'd2, 0, 1, 32'h0, 0, "R4 word read irq 28-31");
        acc(1, 12'h405, 2'd0, 32'h99, 1, 32'h0, 0, "R4 byte write irq 5");
        acc(0, 12'h405, 2'd0, 0, 1, 32'h0, 0, "R4 byte read irq 5");
        // R3 / R10: word write just above the boundary
        acc(1, 12'h420, 2'd2, 32'h4433_2211, 0, 32'h0, 0, "R3 word prio write");
        exp_upd(10'd32, 4'b1111, "R10 word strobe irq 32");
        acc(0, 12'h422, 2'd0, 0, 1, 32'h0000_0033, 0, "R3 lane 2 byte read");
        acc(0, 12'h420, 2'd2, 0, 1, 32'h4433_2211, 0, "R3 word readback");
        // R4: at and above NUM_IRQ
        acc(1, 12'h4FC, 2'd2, 32'h0807_0605, 1, 32'h0, 0, "R3 word write irq 252-255");
        exp_upd(10'd252, 4'b1111, "R10 strobe irq 252");
        acc(0, 12'h4FF, 2'd0, 0, 1, 32'h0000_0008, 0, "R3 byte read irq 255");
        acc(1, 12'h500, 2'd2, 32'h1234_5678, 1, 32'h0, 0, "R4 write irq 256");
        acc(0, 12'h500, 2'd2, 0, 1, 32'h0, 0, "R4 read irq 256");

        // R2: target and pending windows
        acc(1, 12'h805, 2'd0, 32'hFF, 1, 32'h0, 0, "R2 byte write target");
        acc(0, 12'h805, 2'd0, 0, 1, 32'h0, 0, "R2 byte read target");
        acc(1, 12'hBFC, 2'd2, 32'hFFFF_FFFF, 0, 32'h0, 0, "R2 word write target");
        acc(0, 12'hBFC, 2'd2, 0, 0, 32'h0, 0, "R2 word read target");
        acc(1, 12'hF10, 2'd2, 32'hFFFF_FFFF, 1, 32'h0, 0, "R2 word write set-pending");
        acc(0, 12'hF10, 2'd2, 0, 1, 32'h0, 0, "R2 word read set-pending");
        acc(1, 12'hF2F, 2'd0, 32'hFF, 1, 32'h0, 0, "R2 byte write clear-pending");
        acc(0, 12'hF2F, 2'd0, 0, 1, 32'h0, 0, "R2 byte read clear-pending");

        // R7: write-only register
        acc(1, 12'hF00, 2'd2, 32'h0001_0003, 0, 32'h0, 0, "R7 gen write");
        acc(0, 12'hF00, 2'd2, 0, 1, 32'h0, 0, "R7 gen read");

        // R6: misaligned and unmapped word accesses
        acc(1, 12'h402, 2'd2, 32'hFFFF_FFFF, 1, 32'h0, 1, "R6 misaligned prio word");
        acc(0, 12'h420, 2'd2, 0, 1, 32'h4433_2211, 0, "R6 misaligned write left prio");
        acc(0, 12'h100, 2'd2, 0, 1, 32'h0, 1, "R6 unmapped word");
        acc(1, 12'h004, 2'd2, 32'h1, 1, 32'h0, 1, "R6 unmapped next to ctl");
        acc(0, 12'hF34, 2'd2, 0, 1, 32'h0, 1, "R6 unmapped after pending");

        idle(2);

        // R8 / R9: disable-security set, non-secure sees full word
        acc(1, 12'h000, 2'd2, 32'h0000_0047, 1, 32'h0, 0, "R9 secure set DS");
        acc(0, 12'h000, 2'd2, 0, 0, 32'h0000_0077, 0, "R8 ns full view with DS");
        acc(1, 12'h000, 2'd2, 32'h0, 0, 32'h0, 0, "R9 ns wide write with DS");
        acc(0, 12'h000, 2'd2, 0, 1, 32'h0000_0030, 0, "R9 ns write cleared all");
        acc(0, 12'h000, 2'd2, 0, 0, 32'h0000_0010, 0, "R8 ns view after DS clear");

        idle(4);
        done = 1'b1;
        vectors++;
        if (rsp_q.size() != 0 || upd_q.size() != 0) begin
            miscompares++;
            $display("FAIL R11 leftover items: rsp=%0d upd=%0d expected 0 0", rsp_q.size(), upd_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule